// File: doc/BRIEF.md
# SDRAM Data Bus Turnaround Scheduler

This block sits between a memory controller's command sequencer and the shared bidirectional data bus of an SDRAM device. The controller raises a read request or a write request and holds it until the scheduler accepts it. For each accepted read, the scheduler works out the bus cycles in which the device will return data. The first word arrives a CAS latency after the read command, and the rest of the burst follows on consecutive cycles. A capture strobe goes high on each of those words. For an accepted write, the output enable goes high on the cycle of the write command and stays high for one burst.

Read data can still be on its way when a write is requested. In that case the scheduler keeps the controller from driving into the device's read data. A configuration input selects one of three ways to do this. The scheduler can hold the write until the read burst has drained. It can issue a burst-terminate command that cancels the later read words. Or it can raise the data mask over the read words that are still due, which keeps the device off the bus. In every mode at least one cycle with nobody driving separates a read word the device drove from the first write word.

Top module: `sdram_dq_turnaround`

## Requirements
- R1: While reset is held low, and after it with no requests, rd_ack, wr_ack, bst_cmd, rd_valid, dq_oe and dq_mask are all low.
- R2: If rd_ack is high in cycle t, rd_valid is high in cycles t+CL through t+CL+BL-1. CL is 2 when cas_sel=0 and 3 when cas_sel=1. BL is 1, 2, 4 or 8 for burst_code 0, 1, 2, 3.
- R3: If wr_ack is high in cycle t, dq_oe is high in cycles t through t+BL-1.
- R4: dq_oe and rd_valid are never high in the same cycle.
- R5: dq_oe is never high in the cycle right after a cycle with rd_valid high.
- R6: With policy 0 (wait), a write is accepted only when no read word is still due. The cycle before acceptance carries no read word.
- R7: With policy 1 (terminate), a pending write with read words due at offsets CL or later from the current cycle raises bst_cmd for exactly one cycle. Those later words are cancelled and never reach rd_valid. Words at smaller offsets are still delivered.
- R8: With policy 2 (mask), every read word that arrives while a write is pending, or before the in-flight reads have drained after the write's acceptance, raises dq_mask and keeps rd_valid low. The write may be accepted while such words are still due.
- R9: A read is accepted only while no write is requested, no write burst is being driven, and no masking is in progress. When both requests arrive together, the write goes first.
- R10: At most one of rd_ack, wr_ack and bst_cmd is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cas_sel | input | 1 | CAS latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| burst_code | input | 2 | Burst length code: words = 2**burst_code |
| policy | input | 2 | Contention handling: 0 wait, 1 terminate, 2 mask, 3 behaves as wait |
| rd_req | input | 1 | Read request, held until rd_ack |
| wr_req | input | 1 | Write request, held until wr_ack |
| rd_ack | output | 1 | Read command issued this cycle |
| wr_ack | output | 1 | Write command issued this cycle, first write word on the bus |
| bst_cmd | output | 1 | Burst-terminate command issued this cycle |
| rd_valid | output | 1 | A read word driven by the device is on the bus this cycle; capture it |
| dq_oe | output | 1 | Controller drives the data bus this cycle |
| dq_mask | output | 1 | Data mask high, suppressing the device's read word this cycle |

## Verification
The assertions assume that cas_sel, burst_code and policy only change while no read word is due and no write burst is active. They also assume that the controller holds each request until it is acknowledged. The directed scenarios keep to both rules: each scenario sets the configuration during idle cycles, and the bench lowers a request only in the cycle after it sees the matching acknowledge. The contention cases raise a write request either while a read burst is in flight or together with a read request, and they check the exact cycle of every strobe and command against timing worked out from CL and BL.

// File: rtl/sdtat_pkg.sv
package sdtat_pkg;
    // How a write that meets in-flight read data is handled.
    typedef enum logic [1:0] {
        POL_WAIT = 2'd0,
        POL_TERM = 2'd1,
        POL_MASK = 2'd2,
        POL_RSVD = 2'd3
    } policy_e;

    // Smallest selectable CAS latency; the select bit adds to it.
    localparam int unsigned CL_BASE = 2;
endpackage

// File: rtl/sdtat_rd_window.sv
// Read-arrival window: one bit per future bus cycle. Bit k set means a read
// word will be on the bus k cycles from now. The register shifts by one each
// cycle. A read command loads its burst at offsets CL..CL+BL-1. Cancel clears
// every word at an offset of CL or more.
// Assumes cl_i and bl_i stay stable while words are pending.
module sdtat_rd_window #(
    parameter int OCC_W = 11,
    parameter int LAT_W = 2,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             cancel_i,
    input  logic [LAT_W-1:0] cl_i,
    input  logic [CNT_W-1:0] bl_i,
    output logic [OCC_W-1:0] occ_o
);
    logic [OCC_W-1:0] occ_q, keep, occ_d;

    // Next window: drop cancelled words, advance one cycle, add a new burst.
    always_comb begin
        for (int i = 0; i < OCC_W; i++) begin
            keep[i] = occ_q[i] & ~(cancel_i & (i >= int'(cl_i)));
        end
        occ_d = {1'b0, keep[OCC_W-1:1]};
        for (int i = 0; i < OCC_W; i++) begin
            if (load_i && (i + 1 >= int'(cl_i)) && (i + 1 < int'(cl_i) + int'(bl_i)))
                occ_d[i] = 1'b1;
        end
    end

    // Window register.
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign occ_o = occ_q;
endmodule

// File: rtl/sdtat_wr_burst.sv
// Write burst counter. start_i marks the cycle of the write command, which
// carries the first word. busy_o is high while later words of the burst are
// still to be driven. Assumes words_i >= 1.
module sdtat_wr_burst #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] words_i,
    output logic             busy_o
);
    logic [CNT_W-1:0] left_q;

    // Count down the words that remain after the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)            left_q <= '0;
        else if (start_i)      left_q <= words_i - CNT_W'(1);
        else if (left_q != '0) left_q <= left_q - CNT_W'(1);
    end

    assign busy_o = (left_q != '0);
endmodule

// File: rtl/sdram_dq_turnaround.sv
// Data bus turnaround scheduler for an SDRAM data bus. It accepts read and
// write requests, times the arrival of read words, drives the output enable
// for write bursts, and settles read/write overlap by waiting, by burst
// terminate, or by masking, as the policy input selects.
// Assumes the configuration inputs change only while the bus is idle, and
// that each request is held until it is acknowledged.
module sdram_dq_turnaround
    import sdtat_pkg::*;
#(
    parameter int CL_MAX    = 3,
    parameter int BL_CODE_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cas_sel,
    input  logic [1:0] burst_code,
    input  logic [1:0] policy,
    input  logic       rd_req,
    input  logic       wr_req,
    output logic       rd_ack,
    output logic       wr_ack,
    output logic       bst_cmd,
    output logic       rd_valid,
    output logic       dq_oe,
    output logic       dq_mask
);
    localparam int BL_MAX = 1 << ((1 << BL_CODE_W) - 1);
    localparam int OCC_W  = CL_MAX + BL_MAX;
    localparam int LAT_W  = $clog2(CL_MAX + 1);
    localparam int CNT_W  = $clog2(BL_MAX + 1);

    policy_e          pol;
    logic [LAT_W-1:0] cl_cyc;
    logic [CNT_W-1:0] bl_words;
    logic [OCC_W-1:0] occ, late_sel;
    logic             occ_any, occ_late, occ_after;
    logic             wr_busy, masking, mask_now, drv_now, bus_clear;
    logic             drv_prev_q, mask_hold_q;

    // Decode the configuration inputs.
    always_comb begin
        pol      = policy_e'(policy);
        cl_cyc   = LAT_W'(CL_BASE) + LAT_W'(cas_sel);
        bl_words = CNT_W'(1) << burst_code;
    end

    // Select the window bits at offsets a burst terminate would cancel.
    always_comb begin
        for (int i = 0; i < OCC_W; i++) late_sel[i] = (i >= int'(cl_cyc));
    end

    // Summarise the read window.
    assign occ_any   = |occ;
    assign occ_late  = |(occ & late_sel);
    assign occ_after = |occ[OCC_W-1:1];

    // Decide masking, device drive and command issue for this cycle.
    always_comb begin
        masking   = (pol == POL_MASK) & (wr_req | mask_hold_q);
        mask_now  = masking & occ[0];
        drv_now   = occ[0] & ~mask_now;
        bus_clear = (pol == POL_MASK) ? 1'b1 : ~occ_any;
        wr_ack    = wr_req & ~wr_busy & ~drv_now & ~drv_prev_q & bus_clear;
        bst_cmd   = (pol == POL_TERM) & wr_req & ~wr_busy & occ_late;
        rd_ack    = rd_req & ~wr_req & ~wr_busy & ~mask_hold_q;
    end

    // Remember last cycle's device drive, and keep masking until reads drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_prev_q  <= 1'b0;
            mask_hold_q <= 1'b0;
        end else begin
            drv_prev_q  <= drv_now;
            mask_hold_q <= masking & occ_after;
        end
    end

    sdtat_rd_window #(
        .OCC_W (OCC_W),
        .LAT_W (LAT_W),
        .CNT_W (CNT_W)
    ) u_rd_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (rd_ack),
        .cancel_i (bst_cmd),
        .cl_i     (cl_cyc),
        .bl_i     (bl_words),
        .occ_o    (occ)
    );

    sdtat_wr_burst #(
        .CNT_W (CNT_W)
    ) u_wr_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_ack),
        .words_i (bl_words),
        .busy_o  (wr_busy)
    );

    assign rd_valid = drv_now;
    assign dq_mask  = mask_now;
    assign dq_oe    = wr_ack | wr_busy;
endmodule

// File: rtl/sdtat_checker.sv
// Protocol checker for sdram_dq_turnaround. It looks only at the top-level
// ports and is attached to every instance by the bind statement at the end of
// this file.
module sdtat_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] policy,
    input logic       wr_req,
    input logic       rd_ack,
    input logic       wr_ack,
    input logic       bst_cmd,
    input logic       rd_valid,
    input logic       dq_oe,
    input logic       dq_mask
);
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && rd_valid));                                   // R4
    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !dq_oe);                                    // R5
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> dq_oe);                                       // R3
    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_ack, wr_ack, bst_cmd}));                    // R10
    AST_READ_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (!wr_req && !dq_oe && !dq_mask));             // R9
    AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        dq_mask |-> (!rd_valid && policy == 2'd2));              // R8
    AST_BST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bst_cmd |-> (wr_req && policy == 2'd1));                 // R7
    AST_BST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        bst_cmd |=> !bst_cmd);                                   // R7
endmodule

bind sdram_dq_turnaround sdtat_checker u_sdtat_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .policy   (policy),
    .wr_req   (wr_req),
    .rd_ack   (rd_ack),
    .wr_ack   (wr_ack),
    .bst_cmd  (bst_cmd),
    .rd_valid (rd_valid),
    .dq_oe    (dq_oe),
    .dq_mask  (dq_mask)
);

// File: tb/sdram_dq_turnaround_bench.sv
`timescale 1ns/1ps
module sdram_dq_turnaround_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cas_sel = 1'b0;
    logic [1:0] burst_code = 2'd0;
    logic [1:0] policy = 2'd0;
    logic       rd_req = 1'b0;
    logic       wr_req = 1'b0;
    logic       rd_ack, wr_ack, bst_cmd, rd_valid, dq_oe, dq_mask;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Per-scenario traces: bit c is the output's value in cycle c.
    logic [31:0] t_rdack, t_wrack, t_bst, t_rv, t_oe, t_dqm;

    always #2 clk = ~clk;

    sdram_dq_turnaround u_sdram_dq_turnaround (
        .clk        (clk),
        .rst_n      (rst_n),
        .cas_sel    (cas_sel),
        .burst_code (burst_code),
        .policy     (policy),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .rd_ack     (rd_ack),
        .wr_ack     (wr_ack),
        .bst_cmd    (bst_cmd),
        .rd_valid   (rd_valid),
        .dq_oe      (dq_oe),
        .dq_mask    (dq_mask)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Run one scenario. Each request is raised from its start cycle and held
    // until acknowledged; a start cycle of -1 means no such request.
    task automatic run(input logic cs, input logic [1:0] bc, input logic [1:0] pol,
                       input int rd_at, input int rd_at2, input int wr_at, input int n);
        bit rd_want = 1'b0;
        bit wr_want = 1'b0;
        @(negedge clk);
        cas_sel = cs; burst_code = bc; policy = pol;
        t_rdack = '0; t_wrack = '0; t_bst = '0; t_rv = '0; t_oe = '0; t_dqm = '0;
        for (int c = 0; c < n; c++) begin
            if (c > 0) @(negedge clk);
            if (c == rd_at || c == rd_at2) rd_want = 1'b1;
            if (c == wr_at) wr_want = 1'b1;
            rd_req = rd_want;
            wr_req = wr_want;
            #1;
            t_rdack[c] = rd_ack; t_wrack[c] = wr_ack; t_bst[c] = bst_cmd;
            t_rv[c] = rd_valid;  t_oe[c] = dq_oe;     t_dqm[c] = dq_mask;
            if (rd_ack) rd_want = 1'b0;
            if (wr_ack) wr_want = 1'b0;
        end
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset cmds", {29'd0, rd_ack, wr_ack, bst_cmd}, 32'd0);
        chk("R1", "reset bus", {29'd0, rd_valid, dq_oe, dq_mask}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "idle cmds", {29'd0, rd_ack, wr_ack, bst_cmd}, 32'd0);
        chk("R1", "idle bus", {29'd0, rd_valid, dq_oe, dq_mask}, 32'd0);
    endtask

    task automatic t_read_cl2_bl4();
        run(1'b0, 2'd2, 2'd0, 0, -1, -1, 12);
        chk("R2", "cl2 bl4 rd_ack", t_rdack, 32'h1);
        chk("R2", "cl2 bl4 rd_valid", t_rv, 32'h3C);
    endtask

    task automatic t_read_cl3_bl1();
        run(1'b1, 2'd0, 2'd0, 0, -1, -1, 10);
        chk("R2", "cl3 bl1 rd_valid", t_rv, 32'h8);
    endtask

    task automatic t_read_pair();
        run(1'b0, 2'd1, 2'd0, 0, 2, -1, 12);
        chk("R2", "pair rd_ack", t_rdack, 32'h5);
        chk("R2", "pair rd_valid", t_rv, 32'h3C);
    endtask

    task automatic t_write_alone();
        run(1'b0, 2'd2, 2'd0, -1, -1, 0, 10);
        chk("R3", "write wr_ack", t_wrack, 32'h1);
        chk("R3", "write dq_oe", t_oe, 32'hF);
    endtask

    task automatic t_wait_policy();
        run(1'b0, 2'd2, 2'd0, 0, -1, 1, 16);
        chk("R6", "wait rd_valid", t_rv, 32'h3C);
        chk("R6", "wait wr_ack", t_wrack, 32'h80);
        chk("R3", "wait dq_oe", t_oe, 32'h780);
        chk("R4", "wait overlap", t_oe & t_rv, 32'h0);
        chk("R5", "wait gap", t_oe & (t_rv << 1), 32'h0);
    endtask

    task automatic t_term_policy();
        run(1'b0, 2'd3, 2'd1, 0, -1, 1, 16);
        chk("R7", "term bst_cmd", t_bst, 32'h2);
        chk("R7", "term rd_valid", t_rv, 32'h4);
        chk("R7", "term wr_ack", t_wrack, 32'h10);
        chk("R3", "term dq_oe", t_oe, 32'hFF0);
        chk("R10", "term cmd overlap",
            (t_rdack & t_wrack) | (t_rdack & t_bst) | (t_wrack & t_bst), 32'h0);
    endtask

    task automatic t_mask_policy();
        run(1'b1, 2'd3, 2'd2, 0, -1, 5, 18);
        chk("R8", "mask rd_valid", t_rv, 32'h18);
        chk("R8", "mask dq_mask", t_dqm, 32'h7E0);
        chk("R8", "mask wr_ack", t_wrack, 32'h40);
        chk("R3", "mask dq_oe", t_oe, 32'h3FC0);
        chk("R5", "mask gap", t_oe & (t_rv << 1), 32'h0);
    endtask

    task automatic t_read_yields();
        run(1'b0, 2'd2, 2'd0, 0, -1, 0, 14);
        chk("R9", "yield wr_ack", t_wrack, 32'h1);
        chk("R9", "yield rd_ack", t_rdack, 32'h10);
        chk("R9", "yield rd_valid", t_rv, 32'h3C0);
        chk("R4", "yield overlap", t_oe & t_rv, 32'h0);
    endtask

    initial begin
        t_reset();
        t_read_cl2_bl4();
        t_read_cl3_bl1();
        t_read_pair();
        t_write_alone();
        t_wait_policy();
        t_term_policy();
        t_mask_policy();
        t_read_yields();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule